// File: doc/BRIEF.md
# Configurable MCU Port Controller

An eight-pin general-purpose port for a microcontroller. The MCU reaches it through a small synchronous register bus. Per-pin configuration registers set three things for each pin: where its output value comes from (a data-out register bit or a low address bit of the MCU), whether the pin is driven at all, and whether the driver is push-pull or open-drain. The pads are modelled as separate input, output-value and output-enable vectors. A pin whose enable is low is high impedance.

An address strobe captures the pin inputs into a latch, so that upper address bits arriving on the port can be held. A port-wide peripheral mode turns all pins into a tri-state buffer for the MCU data bus. That buffer carries data only while one of two peripheral selects is active. The MCU read and write strobes set its direction. While peripheral mode is set, the per-pin I/O functions have no effect on the pins.

Register writes take effect on the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_ofs`. The register bus has no handshake. A write is taken in every cycle in which `bus_wr` is high, and the port never applies back-pressure.

Top module: `mcu_port_ctrl`

## Requirements
- R1: Control bit i selects the source for pin i. A 0 takes data-out bit i (MCU I/O) and a 1 takes `mcu_addr[i]` (address out). Every register bit i acts only on pin i.
- R2: Register offsets on `bus_ofs` are: 0 data-out, 1 live pin inputs (read-only, writes ignored), 2 control, 4 direction, 6 drive select, 7 mode. The mode register keeps only bit 7, the peripheral enable, and reads its other bits as 0. Offsets 3 and 5 read 0. Each configuration register reads back the last value written to it.
- R3: After reset, every register reads 00h and no pin is driven.
- R4: A direction bit of 1 enables pin i's driver. A direction bit of 0 holds `pin_oe[i]` low. `pin_out[i]` is 0 whenever `pin_oe[i]` is 0.
- R5: With a drive select bit of 1, pin i is open-drain: it is driven (out 0) only when its value is 0, and is high impedance for a 1. With a drive select bit of 0, the pin is push-pull.
- R6: `addr_in` follows `pin_in` while `addr_strobe` is high. It keeps the value captured at the last rising clock edge with the strobe high for as long as the strobe stays low.
- R7: In peripheral mode, with `psel0` or `psel1` active: `ext_wr` alone drives all pins with `ext_wdata`; `ext_rd` alone presents `pin_in` on `ext_rdata`, raises `ext_rdata_oe` and leaves all pins undriven.
- R8: In peripheral mode, with neither select active, no pin is driven and `ext_rdata_oe` is 0.
- R9: Peripheral mode overrides the data-out, control, direction and drive settings for every pin. Those registers still accept writes, and they govern the pins again once the mode bit is cleared.
- R10: In peripheral mode, with `ext_rd` and `ext_wr` both high, neither direction is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ofs | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| mcu_addr | input | 8 | Low MCU address bits for address-out pins |
| addr_strobe | input | 1 | Address strobe for the input latch |
| addr_in | output | 8 | Latched address inputs |
| psel0 | input | 1 | Peripheral select 0, active high |
| psel1 | input | 1 | Peripheral select 1, active high |
| ext_rd | input | 1 | MCU read strobe for peripheral mode |
| ext_wr | input | 1 | MCU write strobe for peripheral mode |
| ext_wdata | input | 8 | MCU data bus toward the pins |
| ext_rdata | output | 8 | Pin data toward the MCU data bus |
| ext_rdata_oe | output | 1 | Enable for ext_rdata onto the MCU bus |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The hardest case is peripheral mode overriding a port that already has a full per-pin setup. The bench first programs a driven, mixed configuration and then sets the mode bit. While the mode bit is set, it rewrites data-out and checks that the pins do not move. It then cycles the selects and strobes through read, write, idle and conflict. Last, it clears the mode bit and checks that the data written during peripheral mode now appears on the pins. For the address latch, the strobe falls in the same cycle that the pin inputs change, which shows that the latch holds the last captured value.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_DOUT = 3'h0;
  localparam logic [OFS_W-1:0] OFS_PINS = 3'h1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'h2;
  localparam logic [OFS_W-1:0] OFS_DIR  = 3'h4;
  localparam logic [OFS_W-1:0] OFS_DRV  = 3'h6;
  localparam logic [OFS_W-1:0] OFS_MODE = 3'h7;

  typedef struct packed {
    logic addr_sel;
    logic dir;
    logic open_drain;
    logic dout;
  } pin_cfg_t;
endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
  import mcu_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     ctrl_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     drv_q,
  output logic             periph_en,
  output logic [W-1:0]     bus_rdata
);
  localparam int MODE_BIT = W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      ctrl_q    <= '0;
      dir_q     <= '0;
      drv_q     <= '0;
      periph_en <= 1'b0;
    end else if (bus_wr) begin
      case (bus_ofs)
        OFS_DOUT: dout_q    <= bus_wdata;
        OFS_CTRL: ctrl_q    <= bus_wdata;
        OFS_DIR:  dir_q     <= bus_wdata;
        OFS_DRV:  drv_q     <= bus_wdata;
        OFS_MODE: periph_en <= bus_wdata[MODE_BIT];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_ofs)
      OFS_DOUT: bus_rdata = dout_q;
      OFS_PINS: bus_rdata = pin_in;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_DRV:  bus_rdata = drv_q;
      OFS_MODE: bus_rdata[MODE_BIT] = periph_en;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a control write lands on the next edge
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ofs == OFS_CTRL) |=> (ctrl_q == $past(bus_wdata)));

  // R3: configuration holds while no write is presented
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(dir_q) && $stable(drv_q) && $stable(ctrl_q)));
endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr_strobe,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] addr_in
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_q <= '0;
    else if (addr_strobe) held_q <= pin_in;
  end

  assign addr_in = addr_strobe ? pin_in : held_q;

  // R6: with the strobe low on two edges, the latched value does not move
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe && $past(!addr_strobe)) |-> (addr_in == $past(addr_in)));
endmodule

// File: rtl/port_pin_drive.sv
module port_pin_drive
  import mcu_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dout_q,
  input  logic [W-1:0] ctrl_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] drv_q,
  input  logic [W-1:0] mcu_addr,
  input  logic         periph_en,
  input  logic         psel_any,
  input  logic         ext_wr,
  input  logic         ext_rd,
  input  logic [W-1:0] ext_wdata,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic periph_drive;
  assign periph_drive = psel_any & ext_wr & ~ext_rd;

  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_cfg_t cfg;
    logic     val;
    logic     gen_oe;
    logic     gen_out;

    assign cfg     = '{addr_sel: ctrl_q[i], dir: dir_q[i],
                       open_drain: drv_q[i], dout: dout_q[i]};
    assign val     = cfg.addr_sel ? mcu_addr[i] : cfg.dout;
    assign gen_oe  = cfg.dir & (cfg.open_drain ? ~val : 1'b1);
    assign gen_out = gen_oe & val & ~cfg.open_drain;

    assign pin_oe[i]  = periph_en ? periph_drive : gen_oe;
    assign pin_out[i] = periph_en ? (periph_drive & ext_wdata[i]) : gen_out;
  end

  // R1: push-pull address-out pins show the address bit
  p_addr_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> (((pin_out ^ mcu_addr) & ctrl_q & dir_q & ~drv_q) == '0));

  // R4: a pin with direction 0 is never driven outside peripheral mode
  p_dir_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> ((pin_oe & ~dir_q) == '0));

  // R5: open-drain pins never drive high
  p_od_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> ((pin_oe & pin_out & drv_q) == '0));

  // R8: no select in peripheral mode leaves all pins floating
  p_periph_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && !psel_any) |-> (pin_oe == '0));

  // R10: conflicting strobes drive no pin
  p_strobe_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && ext_rd && ext_wr) |-> (pin_oe == '0));
endmodule

// File: rtl/mcu_port_ctrl.sv
module mcu_port_ctrl
  import mcu_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     mcu_addr,
  input  logic             addr_strobe,
  output logic [W-1:0]     addr_in,
  input  logic             psel0,
  input  logic             psel1,
  input  logic             ext_rd,
  input  logic             ext_wr,
  input  logic [W-1:0]     ext_wdata,
  output logic [W-1:0]     ext_rdata,
  output logic             ext_rdata_oe,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe
);
  logic [W-1:0] dout_q, ctrl_q, dir_q, drv_q;
  logic         periph_en;
  logic         psel_any;

  assign psel_any = psel0 | psel1;

  port_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_in(pin_in), .dout_q(dout_q),
    .ctrl_q(ctrl_q), .dir_q(dir_q), .drv_q(drv_q),
    .periph_en(periph_en), .bus_rdata(bus_rdata)
  );

  port_addr_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
    .pin_in(pin_in), .addr_in(addr_in)
  );

  port_pin_drive #(.W(W)) u_drive (
    .clk(clk), .rst_n(rst_n), .dout_q(dout_q), .ctrl_q(ctrl_q),
    .dir_q(dir_q), .drv_q(drv_q), .mcu_addr(mcu_addr),
    .periph_en(periph_en), .psel_any(psel_any), .ext_wr(ext_wr),
    .ext_rd(ext_rd), .ext_wdata(ext_wdata), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  assign ext_rdata_oe = periph_en & psel_any & ext_rd & ~ext_wr;
  assign ext_rdata    = ext_rdata_oe ? pin_in : '0;

  // R7: a peripheral read never drives the pins
  p_periph_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rdata_oe |-> (pin_oe == '0));
endmodule

// File: tb/mcu_port_ctrl_bench.sv
module mcu_port_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_ofs = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] mcu_addr = '0;
  logic       addr_strobe = 1'b0;
  logic [7:0] addr_in;
  logic       psel0 = 1'b0, psel1 = 1'b0, ext_rd = 1'b0, ext_wr = 1'b0;
  logic [7:0] ext_wdata = '0;
  logic [7:0] ext_rdata;
  logic       ext_rdata_oe;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcu_port_ctrl u_mcu_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mcu_addr(mcu_addr),
    .addr_strobe(addr_strobe), .addr_in(addr_in), .psel0(psel0),
    .psel1(psel1), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_rdata_oe(ext_rdata_oe), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_ofs = ofs; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string what, input logic [2:0] ofs, input logic [7:0] exp);
    bus_ofs = ofs;
    #1;
    check(what, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_check("R3 data-out reset", 3'h0, 8'h00);
    rd_check("R3 control reset", 3'h2, 8'h00);
    rd_check("R3 direction reset", 3'h4, 8'h00);
    rd_check("R3 drive reset", 3'h6, 8'h00);
    rd_check("R3 mode reset", 3'h7, 8'h00);
    check("R3 no pin driven", pin_oe, 8'h00);
  endtask

  task automatic t_regs;
    wr_reg(3'h0, 8'h11); wr_reg(3'h2, 8'h22); wr_reg(3'h4, 8'h44);
    wr_reg(3'h6, 8'h66);
    rd_check("R2 data-out readback", 3'h0, 8'h11);
    rd_check("R2 control readback", 3'h2, 8'h22);
    rd_check("R2 direction readback", 3'h4, 8'h44);
    rd_check("R2 drive readback", 3'h6, 8'h66);
    wr_reg(3'h3, 8'hFF);
    rd_check("R2 gap offset reads 0", 3'h3, 8'h00);
    wr_reg(3'h7, 8'h7F);
    rd_check("R2 mode ignores low bits", 3'h7, 8'h00);
    pin_in = 8'h96;
    wr_reg(3'h1, 8'h00);
    rd_check("R2 pin state read, write ignored", 3'h1, 8'h96);
    rd_check("R2 data-out untouched by pin write", 3'h0, 8'h11);
    wr_reg(3'h4, 8'h00);
  endtask

  task automatic t_mcu_io;
    wr_reg(3'h0, 8'hA5); wr_reg(3'h2, 8'h00); wr_reg(3'h6, 8'h00);
    check("R4 direction 0 floats", pin_oe, 8'h00);
    check("R4 undriven output is 0", pin_out, 8'h00);
    wr_reg(3'h4, 8'hFF);
    check("R1 MCU I/O drives data-out (oe)", pin_oe, 8'hFF);
    check("R1 MCU I/O drives data-out", pin_out, 8'hA5);
    wr_reg(3'h4, 8'h0F);
    check("R4 partial direction oe", pin_oe, 8'h0F);
    check("R4 partial direction out", pin_out, 8'h05);
  endtask

  task automatic t_addr_out;
    wr_reg(3'h4, 8'hFF);
    mcu_addr = 8'h3C;
    wr_reg(3'h2, 8'hF0);
    check("R1 mixed address/data pins", pin_out, 8'h35);
    mcu_addr = 8'hC3;
    #1;
    check("R1 address pins follow mcu_addr", pin_out, 8'hC5);
    wr_reg(3'h2, 8'h00);
  endtask

  task automatic t_open_drain;
    wr_reg(3'h6, 8'hFF);
    check("R5 open-drain enables only zeros", pin_oe, 8'h5A);
    check("R5 open-drain drives low", pin_out, 8'h00);
    wr_reg(3'h6, 8'h0F);
    check("R5 mixed drive oe", pin_oe, 8'hFA);
    check("R5 mixed drive out", pin_out, 8'hA0);
    wr_reg(3'h6, 8'h00);
  endtask

  task automatic t_latch;
    @(negedge clk);
    addr_strobe = 1'b1; pin_in = 8'h12;
    #1;
    check("R6 latch transparent", addr_in, 8'h12);
    @(negedge clk);
    pin_in = 8'h34;
    #1;
    check("R6 latch follows", addr_in, 8'h34);
    @(negedge clk);
    addr_strobe = 1'b0; pin_in = 8'h56;
    #1;
    check("R6 latch holds at fall", addr_in, 8'h34);
    @(negedge clk);
    pin_in = 8'h78;
    @(negedge clk);
    #1;
    check("R6 latch holds while low", addr_in, 8'h34);
  endtask

  task automatic t_periph;
    wr_reg(3'h0, 8'hA5); wr_reg(3'h4, 8'hFF);
    wr_reg(3'h7, 8'h80);
    rd_check("R2 mode bit readback", 3'h7, 8'h80);
    ext_wr = 1'b1; ext_wdata = 8'hC3;
    #1;
    check("R8 no select floats", pin_oe, 8'h00);
    wr_reg(3'h0, 8'h5A);
    check("R9 data-out write no effect (oe)", pin_oe, 8'h00);
    check("R9 data-out write no effect (out)", pin_out, 8'h00);
    psel0 = 1'b1;
    #1;
    check("R7 write drives all pins", pin_oe, 8'hFF);
    check("R7 write data on pins", pin_out, 8'hC3);
    check("R7 no read during write", {7'd0, ext_rdata_oe}, 8'h00);
    ext_wr = 1'b0; ext_rd = 1'b1; pin_in = 8'h5A;
    #1;
    check("R7 read floats pins", pin_oe, 8'h00);
    check("R7 read data", ext_rdata, 8'h5A);
    check("R7 read enable", {7'd0, ext_rdata_oe}, 8'h01);
    psel0 = 1'b0; psel1 = 1'b1; pin_in = 8'hE1;
    #1;
    check("R7 second select read", ext_rdata, 8'hE1);
    ext_wr = 1'b1;
    #1;
    check("R10 clash no pin drive", pin_oe, 8'h00);
    check("R10 clash no bus drive", {7'd0, ext_rdata_oe}, 8'h00);
    psel1 = 1'b0; ext_wr = 1'b0;
    #1;
    check("R8 read without select", {7'd0, ext_rdata_oe}, 8'h00);
    ext_rd = 1'b0;
    wr_reg(3'h7, 8'h00);
    check("R9 config returns (oe)", pin_oe, 8'hFF);
    check("R9 data written in mode appears", pin_out, 8'h5A);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_mcu_io;
    t_addr_out;
    t_open_drain;
    t_latch;
    t_periph;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule